// File: doc/BRIEF.md
# Segment Address Translation Unit

This unit turns a logical address into a 32-bit linear address. A logical address pairs a 16-bit segment selector with a 32-bit offset. When a new selector is loaded, the unit decodes the selector. Unless the selector is the null selector, it reads the matching 8-byte descriptor through a 32-bit memory read port. The read takes two words, low word first, and the descriptor comes from either the global or the local descriptor table. The unit keeps the fields it needs from that descriptor in a cache register.

On every access after that, the unit does not touch memory. It runs four protection checks against the cached copy: null selector, segment presence, privilege, and offset limit. It returns the linear address one cycle later, or a fault code instead. A fetch keeps the unit busy for three cycles. During that time, loads and accesses are ignored, so the surrounding pipeline must hold them until busy drops.

Top module: `seg_xlate`

## Requirements
- R1: The descriptor address is the table base plus 8 times the selector index. The index is selector bits 15:3. Selector bit 2 picks the table: 0 is the global table, 1 is the local table. The low word is read at that address and the high word at the address plus 4, on the next cycle. Read data is sampled one cycle after `mem_rd`.
- R2: `busy` is high for exactly three cycles after an accepted load of a non-null selector. `mem_rd` is high only while `busy` is high. A load or access presented while `busy` is high is ignored: it causes no response and does not replace the cached descriptor.
- R3: An access never reads memory. It uses the descriptor cached at the last load.
- R4: Index 0 with bit 2 clear (any RPL) is the null selector. Loading it performs no read. Every later access reports fault code 1. Accesses made before any load also report fault code 1.
- R5: If descriptor bit 47 (present) is 0, an access reports fault code 2.
- R6: Descriptor bits 46:45 hold the descriptor privilege level. An access reports fault code 3 when either `cpl` or the RPL (selector bits 1:0 at load) is numerically greater than it.
- R7: The 20-bit limit is descriptor bits 51:48 joined above bits 15:0. With byte granularity, an offset above the limit reports fault code 4. An offset equal to the limit is allowed.
- R8: When descriptor bit 55 is 1, the effective limit is the 20-bit limit shifted left by 12, with 0xFFF in the low bits.
- R9: The response appears one cycle after the accepted access. With fault code 0, `out_lin` is the base plus the offset, modulo 2^32. The base is descriptor bits 63:56 above bits 39:16. With any other fault code, `out_lin` is 0.
- R10: When several faults apply, the code reported follows the order null, then not-present, then privilege, then limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gdt_base | input | 32 | Global table base address |
| ldt_base | input | 32 | Local table base address |
| cpl | input | 2 | Current privilege level for accesses |
| load_valid | input | 1 | Load a new selector |
| load_sel | input | 16 | Selector to load |
| acc_valid | input | 1 | Translate an offset |
| acc_off | input | 32 | Offset to translate |
| busy | output | 1 | Descriptor fetch in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, one cycle after the strobe |
| out_valid | output | 1 | Translation result valid |
| out_fault | output | 3 | Fault code (0 none, 1 null, 2 absent, 3 privilege, 4 limit) |
| out_lin | output | 32 | Linear address |

## Verification
The hardest situations to reach from the ports are the ones where two faults overlap, and an exact limit boundary under 4 KB scaling. A random offset almost never lands on the limit or one past it. The stimulus therefore derives offsets from each random descriptor's effective limit: the limit itself, one past it, one below it, plus a random value. It also sets privilege levels so that privilege and limit faults collide. Directed cases then reach the remaining corners:
- loads and accesses issued in the middle of a fetch;
- a base that wraps past 2^32;
- index 0 in the local table, which must still fetch.

// File: rtl/seg_pkg.sv
package seg_pkg;
    parameter int SEL_W  = 16;
    parameter int WORD_W = 32;
    parameter int DESC_W = 2 * WORD_W;
    parameter int LIM_W  = 20;
    parameter int GRAN_SH = 12;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_PRIV   = 3'd3,
        FLT_LIMIT  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_LO, ST_HI, ST_FIN
    } fetch_e;

    typedef struct packed {
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] lim;
        logic [1:0]        dpl;
        logic              present;
    } seg_info_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] gdt_base,
    input  logic [WORD_W-1:0] ldt_base,
    output logic [WORD_W-1:0] desc_addr,
    output logic              is_null
);
    localparam int IDX_W = SEL_W - 3;

    logic [IDX_W-1:0] idx;
    logic             use_local;

    always_comb begin
        idx       = sel[SEL_W-1:3];
        use_local = sel[2];
        desc_addr = (use_local ? ldt_base : gdt_base)
                  + {{(WORD_W-IDX_W-3){1'b0}}, idx, 3'b000};
        is_null   = (idx == '0) && !use_local;
    end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
    import seg_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output seg_info_t         info
);
    logic [LIM_W-1:0] raw_lim;
    logic             unused_bits;

    assign unused_bits = ^{desc[44:40], desc[54:52]};

    always_comb begin
        raw_lim      = {desc[51:48], desc[15:0]};
        info.base    = {desc[63:56], desc[39:16]};
        info.dpl     = desc[46:45];
        info.present = desc[47];
        if (desc[55])
            info.lim = {raw_lim, {GRAN_SH{1'b1}}};
        else
            info.lim = {{(WORD_W-LIM_W){1'b0}}, raw_lim};
    end
endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
(
    input  seg_info_t         info,
    input  logic              seg_null,
    input  logic [1:0]        rpl,
    input  logic [1:0]        cpl,
    input  logic [WORD_W-1:0] off,
    output fault_e            fault,
    output logic [WORD_W-1:0] lin
);
    logic [1:0] eff_pl;

    always_comb begin
        eff_pl = (cpl > rpl) ? cpl : rpl;
        lin    = info.base + off;
        if (seg_null)
            fault = FLT_NULL;
        else if (!info.present)
            fault = FLT_ABSENT;
        else if (eff_pl > info.dpl)
            fault = FLT_PRIV;
        else if (off > info.lim)
            fault = FLT_LIMIT;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       gdt_base,
    input  logic [31:0]       ldt_base,
    input  logic [1:0]        cpl,
    input  logic              load_valid,
    input  logic [15:0]       load_sel,
    input  logic              acc_valid,
    input  logic [31:0]       acc_off,
    output logic              busy,
    output logic              mem_rd,
    output logic [31:0]       mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [2:0]        out_fault,
    output logic [31:0]       out_lin
);
    typedef struct packed {
        fetch_e            st;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] lo;
        seg_info_t         info;
        logic              seg_null;
        logic [1:0]        rpl;
        logic              out_v;
        fault_e            flt;
        logic [WORD_W-1:0] lin;
    } state_t;

    state_t s_d, s_q;

    logic [WORD_W-1:0] dec_addr;
    logic              dec_null;
    seg_info_t         fetched;
    fault_e            chk_fault;
    logic [WORD_W-1:0] chk_lin;

    seg_sel_decode i_dec (
        .sel       (load_sel),
        .gdt_base  (gdt_base),
        .ldt_base  (ldt_base),
        .desc_addr (dec_addr),
        .is_null   (dec_null)
    );

    seg_desc_unpack i_unpack (
        .desc (DESC_W'({mem_rdata, s_q.lo})),
        .info (fetched)
    );

    seg_check i_chk (
        .info     (s_q.info),
        .seg_null (s_q.seg_null),
        .rpl      (s_q.rpl),
        .cpl      (cpl),
        .off      (acc_off),
        .fault    (chk_fault),
        .lin      (chk_lin)
    );

    always_comb begin
        s_d       = s_q;
        s_d.out_v = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (load_valid) begin
                    s_d.rpl = load_sel[1:0];
                    if (dec_null) begin
                        s_d.seg_null = 1'b1;
                    end else begin
                        s_d.st   = ST_LO;
                        s_d.addr = dec_addr;
                    end
                end
                if (acc_valid) begin
                    s_d.out_v = 1'b1;
                    s_d.flt   = chk_fault;
                    s_d.lin   = (chk_fault == FLT_NONE) ? chk_lin : '0;
                end
            end
            ST_LO: s_d.st = ST_HI;
            ST_HI: begin
                s_d.lo = mem_rdata;
                s_d.st = ST_FIN;
            end
            default: begin
                s_d.info     = fetched;
                s_d.seg_null = 1'b0;
                s_d.st       = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.st       <= ST_IDLE;
            s_q.seg_null <= 1'b1;
            s_q.flt      <= FLT_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy      = (s_q.st != ST_IDLE);
        mem_rd    = (s_q.st == ST_LO) || (s_q.st == ST_HI);
        case (s_q.st)
            ST_LO:   mem_addr = s_q.addr;
            ST_HI:   mem_addr = s_q.addr + 32'd4;
            default: mem_addr = '0;
        endcase
        out_valid = s_q.out_v;
        out_fault = s_q.flt;
        out_lin   = s_q.lin;
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_valid,
    input logic [15:0] load_sel,
    input logic        acc_valid,
    input logic        busy,
    input logic        mem_rd,
    input logic [31:0] mem_addr,
    input logic        out_valid,
    input logic [2:0]  out_fault,
    input logic [31:0] out_lin
);
    AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy); // R2

    AST_HI_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 32'd4)); // R1

    AST_FAULT_ZERO_LIN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault != 3'd0) |-> (out_lin == 32'd0)); // R9

    AST_RESP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(acc_valid && !busy)); // R2

    AST_NO_READ_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !busy && !load_valid) |=> !mem_rd); // R3

    AST_NULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !busy && load_sel[15:2] == 14'd0) |=> !busy); // R4

    AST_FAULT_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault <= 3'd4)); // R10
endmodule

bind seg_xlate seg_xlate_chk i_seg_xlate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (load_valid),
    .load_sel   (load_sel),
    .acc_valid  (acc_valid),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .out_valid  (out_valid),
    .out_fault  (out_fault),
    .out_lin    (out_lin)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
    localparam logic [31:0] GB = 32'h0000_1000;
    localparam logic [31:0] LB = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cpl;
    logic        load_valid;
    logic [15:0] load_sel;
    logic        acc_valid;
    logic [31:0] acc_off;
    logic        busy, mem_rd, out_valid;
    logic [31:0] mem_addr, out_lin;
    logic [31:0] mem_rdata = 32'h0;
    logic [2:0]  out_fault;

    always #10 clk = ~clk;

    seg_xlate i_seg_xlate (
        .clk(clk), .rst_n(rst_n), .gdt_base(GB), .ldt_base(LB), .cpl(cpl),
        .load_valid(load_valid), .load_sel(load_sel), .acc_valid(acc_valid),
        .acc_off(acc_off), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_fault(out_fault),
        .out_lin(out_lin)
    );

    logic [63:0] gtab [16];
    logic [63:0] ltab [16];
    int          rd_count = 0;
    logic        rd_prev = 1'b0;
    logic [31:0] first_addr = 32'h0;
    int          checks = 0;
    int          fails = 0;
    logic        done = 1'b0;

    logic [63:0] m_desc = 64'h0;
    logic        m_null = 1'b1;
    logic [1:0]  m_rpl = 2'd0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [63:0] d;
        if (a >= GB && a < GB + 32'd128) d = gtab[4'((a - GB) >> 3)];
        else if (a >= LB && a < LB + 32'd128) d = ltab[4'((a - LB) >> 3)];
        else d = 64'hDEAD_BEEF_DEAD_BEEF;
        return a[2] ? d[63:32] : d[31:0];
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_word(mem_addr);
            rd_count  <= rd_count + 1;
            if (!rd_prev) first_addr <= mem_addr;
        end
        rd_prev <= mem_rd;
    end

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input logic g, input logic p, input logic [1:0] dpl);
        logic [63:0] d = 64'h0;
        d[15:0]  = lim[15:0];
        d[39:16] = base[23:0];
        d[43:40] = 4'h2;
        d[44]    = 1'b1;
        d[46:45] = dpl;
        d[47]    = p;
        d[51:48] = lim[19:16];
        d[54]    = 1'b1;
        d[55]    = g;
        d[63:56] = base[31:24];
        return d;
    endfunction

    function automatic logic [31:0] eff_lim(input logic [63:0] d);
        logic [19:0] l = {d[51:48], d[15:0]};
        return d[55] ? {l, 12'hFFF} : {12'h0, l};
    endfunction

    function automatic logic [34:0] model(input logic [63:0] d, input logic nul,
                                          input logic [1:0] r, input logic [1:0] c,
                                          input logic [31:0] off);
        logic [1:0] pl = (c > r) ? c : r;
        if (nul) return {3'd1, 32'h0};
        if (!d[47]) return {3'd2, 32'h0};
        if (pl > d[46:45]) return {3'd3, 32'h0};
        if (off > eff_lim(d)) return {3'd4, 32'h0};
        return {3'd0, {d[63:56], d[39:16]} + off};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [15:0] sel);
        @(negedge clk);
        load_valid = 1'b1;
        load_sel   = sel;
        @(negedge clk);
        load_valid = 1'b0;
        while (busy) @(negedge clk);
        m_rpl = sel[1:0];
        if (sel[15:2] == 14'd0) m_null = 1'b1;
        else begin
            m_null = 1'b0;
            m_desc = sel[2] ? ltab[sel[6:3]] : gtab[sel[6:3]];
        end
    endtask

    task automatic do_acc(input logic [31:0] off, input logic [1:0] c, input string tag);
        logic [34:0] e;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_off   = off;
        cpl       = c;
        @(negedge clk);
        acc_valid = 1'b0;
        e = model(m_desc, m_null, m_rpl, c, off);
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " fault"}, 64'(out_fault), 64'(e[34:32]));
        check({tag, " lin"}, 64'(out_lin), 64'(e[31:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            gtab[i] = 64'h0;
            ltab[i] = 64'h0;
        end
        rst_n = 1'b0; cpl = 2'd0; load_valid = 1'b0; load_sel = 16'h0;
        acc_valid = 1'b0; acc_off = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset busy", 64'(busy), 64'd0);
        check("R2 reset mem_rd", 64'(mem_rd), 64'd0);
        check("R9 reset out_valid", 64'(out_valid), 64'd0);

        do_acc(32'h10, 2'd0, "R4 before load");

        gtab[3] = mk_desc(32'h0001_0000, 20'h00FFF, 1'b0, 1'b1, 2'd3);
        n0 = rd_count;
        do_load(16'h0018);
        check("R1 read count", 64'(rd_count - n0), 64'd2);
        check("R1 low word addr", 64'(first_addr), 64'(GB + 32'd24));
        n0 = rd_count;
        do_acc(32'h0000_0FFF, 2'd3, "R7 at limit");
        do_acc(32'h0000_1000, 2'd3, "R7 past limit");
        do_acc(32'h0000_0123, 2'd1, "R9 inside");
        check("R3 no refetch", 64'(rd_count - n0), 64'd0);

        // load and access issued mid-fetch must be ignored
        gtab[4] = mk_desc(32'h0050_0000, 20'h00010, 1'b0, 1'b1, 2'd3);
        n0 = rd_count;
        @(negedge clk);
        load_valid = 1'b1; load_sel = 16'h0020;
        @(negedge clk);
        load_valid = 1'b1; load_sel = 16'h0018;
        acc_valid = 1'b1; acc_off = 32'h4;
        @(negedge clk);
        load_valid = 1'b0; acc_valid = 1'b0;
        check("R2 ignored access", 64'(out_valid), 64'd0);
        check("R2 busy mid-fetch", 64'(busy), 64'd1);
        while (busy) @(negedge clk);
        m_null = 1'b0; m_rpl = 2'd0; m_desc = gtab[4];
        check("R2 single fetch", 64'(rd_count - n0), 64'd2);
        do_acc(32'h0000_0010, 2'd0, "R2 kept first load");

        n0 = rd_count;
        do_load(16'h0002);
        check("R4 null no read", 64'(rd_count - n0), 64'd0);
        do_acc(32'h0, 2'd0, "R4 null access");

        ltab[0] = mk_desc(32'h0300_0000, 20'hFFFFF, 1'b0, 1'b1, 2'd2);
        do_load(16'h0004);
        check("R1 local table addr", 64'(first_addr), 64'(LB));
        do_acc(32'h0000_0800, 2'd2, "R1 local entry 0");

        gtab[5] = mk_desc(32'h0000_8000, 20'h00001, 1'b0, 1'b0, 2'd0);
        do_load(16'h002B);
        do_acc(32'h0000_0100, 2'd3, "R10 absent over priv/limit");
        do_acc(32'h0, 2'd0, "R5 absent");

        gtab[6] = mk_desc(32'h0000_4000, 20'h00100, 1'b0, 1'b1, 2'd1);
        do_load(16'h0030);
        do_acc(32'h10, 2'd2, "R6 cpl above dpl");
        do_acc(32'h10, 2'd1, "R6 cpl equal dpl");
        do_acc(32'h200, 2'd2, "R10 priv over limit");
        do_load(16'h0032);
        do_acc(32'h10, 2'd0, "R6 rpl above dpl");

        gtab[7] = mk_desc(32'h0100_0000, 20'h00002, 1'b1, 1'b1, 2'd0);
        do_load(16'h0038);
        do_acc(32'h0000_2FFF, 2'd0, "R8 scaled limit");
        do_acc(32'h0000_3000, 2'd0, "R8 past scaled limit");

        gtab[8] = mk_desc(32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 2'd0);
        do_load(16'h0040);
        do_acc(32'h0000_2000, 2'd0, "R9 wraparound");

        for (int i = 0; i < 300; i++) begin
            logic [3:0]  idx  = 4'($urandom % 16);
            logic        ti   = 1'($urandom % 2);
            logic [1:0]  rp   = 2'($urandom % 4);
            logic [19:0] lim  = ($urandom % 2) ? 20'($urandom) : 20'($urandom % 64);
            logic [63:0] d    = mk_desc($urandom, lim, 1'($urandom % 2),
                                        ($urandom % 8) != 0, 2'($urandom % 4));
            logic [15:0] sel  = {9'h0, idx, ti, rp};
            if (ti) ltab[idx] = d; else gtab[idx] = d;
            n0 = rd_count;
            do_load(sel);
            check("R1 random fetch count", 64'(rd_count - n0),
                  (sel[15:2] == 14'd0) ? 64'd0 : 64'd2);
            for (int k = 0; k < 4; k++) begin
                logic [31:0] el = m_null ? 32'h0 : eff_lim(m_desc);
                logic [31:0] off;
                case (k)
                    0: off = el;
                    1: off = el + 32'd1;
                    2: off = el - 32'd1;
                    default: off = $urandom;
                endcase
                do_acc(off, 2'($urandom % 4), "R9 random");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule